// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous DRAM of 256K words by 4 bits whose address pins are shared between row and column. A host request carries an 18-bit word address, a read/write flag and 4 bits of write data. The controller splits the address into a 9-bit row and a 9-bit column and sends them in turn on the 9 address pins. The row is captured by the falling row strobe and the column by the falling column strobe. Read data comes back with a one-cycle valid strobe.

After an access the row stays open. A later request to the same row is served by pulsing the column strobe alone. A request to another row, a refresh request from an external scheduler, or the end of the row-strobe low-time budget closes the row and precharges it first. Writes always use early-write timing: write enable is low before the column strobe falls, so the DRAM keeps its data pins in high impedance.

Every timing limit is a parameter in nanoseconds. The block rounds each one up to whole clock cycles at the parameterised clock period, which defaults to 10 ns.

Top module: `pagemode_dram_ctrl`

## Requirements
- R1: During reset and in the cycle after it, dram_ras_n, dram_cas_n, dram_we_n and dram_oe_n are 1, and dram_dq_oe, rd_valid and ref_gnt are 0.
- R2: The row is req_addr[17:9] and the column is req_addr[8:0]. The row is on dram_addr when dram_ras_n falls, and the column is on dram_addr when dram_cas_n falls.
- R3: A request to the row that is already open is served without a new dram_ras_n falling edge: only dram_cas_n is pulsed.
- R4: dram_ras_n stays high for at least the precharge count (RP cycles) before each falling edge. This includes the first activation after reset and an activation that follows a row miss.
- R5: dram_ras_n never stays low for more than the maximum count (RASMAX cycles). An open row left idle is closed before that count is reached.
- R6: Each low period of dram_ras_n lasts at least the minimum row-active count: the larger of the tRAS count and (tRC count minus RP).
- R7: A write is an early write. dram_we_n is low in the sample before dram_cas_n falls and stays low while dram_cas_n is low. dram_dq_oe is 1 and dram_oe_n is 1 at that falling edge, and the word on dram_dq_o is what gets stored.
- R8: During a read, dram_we_n is 1 and dram_oe_n is 0 while dram_cas_n is low, and dram_we_n does not change while dram_cas_n is low. dram_dq_i is sampled in the last cycle of the column-strobe low phase. rd_data is then shown with rd_valid high for exactly one cycle.
- R9: While ref_req is 1, the controller closes any open row and then raises ref_gnt. While ref_gnt is 1, dram_ras_n and dram_cas_n stay 1 and req_ready stays 0.
- R10: After ref_req drops, the RP precharge count is met again before the next row activation.
- R11: Between two column strobes, dram_cas_n is high for at least the column precharge count (CP cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted in this cycle when valid is high |
| req_addr | input | 18 | Word address, row in the upper 9 bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh scheduler asks for the memory |
| ref_gnt | output | 1 | Memory handed to the refresh scheduler |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_o | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 4 | Data from the DRAM |

## Verification
The bench drives the controller through a behavioural DRAM model and uses four kinds of traffic.

- A write followed by a read of the same word shows whether the row and column halves land on the right strobe edges. It also shows whether read sampling waits for the access time, because the model returns inverted data until that time has passed.
- Back-to-back accesses inside one row are told apart from accesses that alternate between rows by counting row activations.
- An open row left idle shows whether the low-time budget closes it.
- A refresh request raised over an open row, with a host request held pending, shows that the controller yields the memory, blocks the host, and precharges again after the grant is released.

// File: rtl/pagemode_dram_pkg.sv
package pagemode_dram_pkg;

    localparam int ROW_W  = 9;
    localparam int COL_W  = 9;
    localparam int DQ_W   = 4;
    localparam int ADDR_W = ROW_W + COL_W;

    typedef enum logic [2:0] {
        ST_PRE,   // row strobe high, precharge running
        ST_IDLE,  // precharged, no row open
        ST_REF,   // memory lent to refresh scheduler
        ST_ROW,   // row strobe low, row address on pins
        ST_CSET,  // column address set-up, column strobe high
        ST_CASL,  // column strobe low
        ST_CASH,  // column strobe precharge
        ST_OPEN   // row open, waiting
    } state_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             we;
        logic [DQ_W-1:0]  wd;
    } access_t;

    // nanoseconds to whole cycles, rounded up, at least one
    function automatic int ns2cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pagemode_dram_timer.sv
module pagemode_dram_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pagemode_dram_budget.sv
module pagemode_dram_budget #(
    parameter int CNT_W     = 16,
    parameter int MIN_LOW   = 14,
    parameter int EXPIRE_AT = 70
) (
    input  logic clk,
    input  logic rst,
    input  logic ras_low,
    output logic min_met,
    output logic expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // number of earlier consecutive cycles with the row strobe low
    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || !ras_low)
            low_cnt <= '0;
        else if (low_cnt != CNT_MAX)
            low_cnt <= low_cnt + 1'b1;
    end

    assign min_met = (low_cnt >= CNT_W'(MIN_LOW - 1));
    assign expire  = (low_cnt >  CNT_W'(EXPIRE_AT));
endmodule

// File: rtl/pagemode_dram_seq.sv
module pagemode_dram_seq
    import pagemode_dram_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RP_CYC  = 4,
    parameter int ROW_CYC = 3,
    parameter int CAS_CYC = 2,
    parameter int CP_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    input  logic              ref_req,
    output logic              ref_gnt,
    input  logic              min_met,
    input  logic              expire,
    output logic              ras_low,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_done,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_o,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_i
);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(RP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ROW = CNT_W'(ROW_CYC - 1);
    localparam logic [CNT_W-1:0] LD_CAS = CNT_W'(CAS_CYC - 1);
    localparam logic [CNT_W-1:0] LD_CP  = CNT_W'(CP_CYC - 1);

    state_t  st, st_n;
    access_t cur_q;
    logic    pend_q, pend_n;
    logic    accept, same_row, must_close, col_phase, drv_phase;

    assign same_row   = (req_addr[ADDR_W-1:COL_W] == cur_q.row);
    assign must_close = ref_req || expire;

    always_comb begin
        st_n      = st;
        pend_n    = pend_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        req_ready = 1'b0;
        accept    = 1'b0;
        unique case (st)
            ST_PRE: if (tmr_done) begin
                if (pend_q) begin
                    st_n = ST_ROW; tmr_load = 1'b1; tmr_val = LD_ROW; pend_n = 1'b0;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (ref_req) begin
                    st_n = ST_REF;
                end else begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        accept = 1'b1; st_n = ST_ROW; tmr_load = 1'b1; tmr_val = LD_ROW;
                    end
                end
            end
            ST_REF: if (!ref_req) begin
                st_n = ST_PRE; tmr_load = 1'b1; tmr_val = LD_RP;
            end
            ST_ROW: if (tmr_done) begin
                st_n = ST_CSET; tmr_load = 1'b1; tmr_val = '0;
            end
            ST_CSET: begin
                st_n = ST_CASL; tmr_load = 1'b1; tmr_val = LD_CAS;
            end
            ST_CASL: if (tmr_done) begin
                st_n = ST_CASH; tmr_load = 1'b1; tmr_val = LD_CP;
            end
            ST_CASH: if (tmr_done) st_n = ST_OPEN;
            ST_OPEN: begin
                if (must_close) begin
                    if (min_met) begin
                        st_n = ST_PRE; tmr_load = 1'b1; tmr_val = LD_RP; pend_n = 1'b0;
                    end
                end else begin
                    req_ready = same_row || min_met;
                    if (req_valid && req_ready) begin
                        accept   = 1'b1;
                        tmr_load = 1'b1;
                        if (same_row) begin
                            st_n = ST_CSET; tmr_val = '0;
                        end else begin
                            st_n = ST_PRE; tmr_val = LD_RP; pend_n = 1'b1;
                        end
                    end
                end
            end
            default: st_n = ST_PRE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_PRE;
            pend_q   <= 1'b0;
            cur_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            st       <= st_n;
            pend_q   <= pend_n;
            rd_valid <= 1'b0;
            if (accept) begin
                cur_q.row <= req_addr[ADDR_W-1:COL_W];
                cur_q.col <= req_addr[COL_W-1:0];
                cur_q.we  <= req_we;
                cur_q.wd  <= req_wdata;
            end
            if (st == ST_CASL && tmr_done && !cur_q.we) begin
                rd_data  <= dram_dq_i;
                rd_valid <= 1'b1;
            end
        end
    end

    // pin decode from the registered state
    assign ras_low    = !(st inside {ST_PRE, ST_IDLE, ST_REF});
    assign col_phase  = (st inside {ST_CSET, ST_CASL, ST_CASH, ST_OPEN});
    assign drv_phase  = (st inside {ST_CSET, ST_CASL});
    assign dram_ras_n = !ras_low;
    assign dram_cas_n = (st != ST_CASL);
    assign dram_we_n  = !(cur_q.we && drv_phase);
    assign dram_oe_n  = !(!cur_q.we && drv_phase);
    assign dram_dq_oe = cur_q.we && drv_phase;
    assign dram_dq_o  = cur_q.wd;
    assign dram_addr  = col_phase ? cur_q.col : cur_q.row;
    assign ref_gnt    = (st == ST_REF);
endmodule

// File: rtl/pagemode_dram_ctrl.sv
module pagemode_dram_ctrl
    import pagemode_dram_pkg::*;
#(
    parameter int CLK_PS      = 10000,
    parameter int CNT_W       = 16,
    parameter int T_RP_NS     = 40,
    parameter int T_RC_NS     = 110,
    parameter int T_RAS_NS    = 60,
    parameter int T_RAC_NS    = 60,
    parameter int T_RAH_NS    = 10,
    parameter int T_CAC_NS    = 15,
    parameter int T_AA_NS     = 30,
    parameter int T_CASW_NS   = 15,
    parameter int T_CP_NS     = 10,
    parameter int T_RASMAX_NS = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_o,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_i
);
    localparam int RP_CYC     = ns2cyc(T_RP_NS, CLK_PS);
    localparam int CAS_CYC    = imax(imax(ns2cyc(T_CAC_NS, CLK_PS), ns2cyc(T_AA_NS, CLK_PS) - 1),
                                     ns2cyc(T_CASW_NS, CLK_PS));
    localparam int ROW_CYC    = imax(ns2cyc(T_RAH_NS, CLK_PS), ns2cyc(T_RAC_NS, CLK_PS) - 1 - CAS_CYC);
    localparam int CP_CYC     = ns2cyc(T_CP_NS, CLK_PS);
    localparam int RASMIN_CYC = imax(ns2cyc(T_RAS_NS, CLK_PS), ns2cyc(T_RC_NS, CLK_PS) - RP_CYC);
    localparam int RASMAX_CYC = ns2cyc(T_RASMAX_NS, CLK_PS);
    localparam int PAGE_CYC   = 1 + CAS_CYC + CP_CYC;
    localparam int EXPIRE_AT  = RASMAX_CYC - PAGE_CYC - 2;

    logic             ras_low, min_met, expire, tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    pagemode_dram_timer #(.CNT_W(CNT_W), .RST_VAL(RP_CYC - 1)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    pagemode_dram_budget #(.CNT_W(CNT_W), .MIN_LOW(RASMIN_CYC), .EXPIRE_AT(EXPIRE_AT)) u_budget (
        .clk(clk), .rst(rst), .ras_low(ras_low), .min_met(min_met), .expire(expire)
    );

    pagemode_dram_seq #(
        .CNT_W(CNT_W), .RP_CYC(RP_CYC), .ROW_CYC(ROW_CYC), .CAS_CYC(CAS_CYC), .CP_CYC(CP_CYC)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_req(ref_req), .ref_gnt(ref_gnt),
        .min_met(min_met), .expire(expire), .ras_low(ras_low),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_done(tmr_done),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_o(dram_dq_o),
        .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
    );
endmodule

// File: rtl/pagemode_dram_chk.sv
module pagemode_dram_chk #(
    parameter int RP_CYC     = 4,
    parameter int RASMIN_CYC = 7,
    parameter int RASMAX_CYC = 1000
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic ref_gnt,
    input logic req_ready,
    input logic rd_valid
);
    int unsigned hi_cnt, lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= 0;
            lo_cnt <= 0;
        end else if (ras_n) begin
            hi_cnt <= hi_cnt + 1;
            lo_cnt <= 0;
        end else begin
            lo_cnt <= lo_cnt + 1;
            hi_cnt <= 0;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && we_n && oe_n && !dq_oe && !rd_valid && !ref_gnt));

    p_cas_in_row_r2: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    p_precharge_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> hi_cnt >= RP_CYC);

    p_ras_budget_r5: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> lo_cnt < RASMAX_CYC);

    p_ras_min_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> lo_cnt >= RASMIN_CYC);

    p_early_write_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !we_n) |-> ($past(!we_n) && dq_oe && oe_n));

    p_we_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && !$fell(cas_n)) |-> $stable(we_n));

    p_rd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    p_no_fight_r8: assert property (@(posedge clk) disable iff (rst)
        !(dq_oe && !oe_n));

    p_grant_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> (ras_n && cas_n && !req_ready));
endmodule

bind pagemode_dram_ctrl pagemode_dram_chk #(
    .RP_CYC(RP_CYC), .RASMIN_CYC(RASMIN_CYC), .RASMAX_CYC(RASMAX_CYC)
) u_chk (
    .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .ref_gnt(ref_gnt), .req_ready(req_ready),
    .rd_valid(rd_valid)
);

// File: tb/pagemode_dram_ctrl_tb.sv
module pagemode_dram_ctrl_tb;
    // expected cycle counts at a 5 ns clock, worked out from the requirements
    localparam int RP     = 8;   // 40 ns
    localparam int RASMIN = 14;  // max(60 ns, 110 ns - 40 ns)
    localparam int RASMAX = 80;  // 400 ns budget used on this bench
    localparam int CP     = 2;   // 10 ns
    localparam int ACC    = 3;   // 15 ns access from column strobe

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic req_ready, rd_valid, ref_gnt;
    logic [3:0] rd_data;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [8:0] daddr;
    logic [3:0] dq_o;
    logic [3:0] dq_i = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pagemode_dram_ctrl #(.CLK_PS(5000), .T_RASMAX_NS(400)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(daddr), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural DRAM model, 64 words indexed by {row[2:0], col[2:0]}
    logic [3:0] mem [64];
    logic ras_p, cas_p, we_p, we_moved;
    int hi_c, lo_c, cashi_c, caslo_c;
    int acts = 0, casf = 0, rdv_cnt = 0;
    logic [8:0] row_l, col_l;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 4'h0;
            ras_p <= 1'b1; cas_p <= 1'b1; we_p <= 1'b1; we_moved <= 1'b0;
            hi_c <= 0; lo_c <= 0; cashi_c <= 0; caslo_c <= 0;
            row_l <= '0; col_l <= '0;
        end else begin
            if (rd_valid) rdv_cnt++;
            if (ras_n) begin hi_c <= hi_c + 1; lo_c <= 0; end
            else begin lo_c <= lo_c + 1; hi_c <= 0; end
            if (cas_n) begin cashi_c <= cashi_c + 1; caslo_c <= 0; end
            else begin caslo_c <= caslo_c + 1; cashi_c <= 0; end
            if (!ras_n && ras_p) begin
                chk(hi_c >= RP, "R4 R10", "row precharge cycles", hi_c, RP);
                row_l <= daddr;
                acts++;
            end
            if (ras_n && !ras_p) begin
                chk(lo_c >= RASMIN, "R6", "row active cycles", lo_c, RASMIN);
                chk(lo_c <= RASMAX, "R5", "row low cycles", lo_c, RASMAX);
            end
            if (!cas_n && cas_p) begin
                chk(!ras_n && cashi_c >= CP, "R11", "column precharge cycles", cashi_c, CP);
                col_l <= daddr;
                casf++;
                we_moved <= 1'b0;
                if (!we_n) begin
                    chk(!we_p && dq_oe && oe_n, "R7", "early write setup",
                        int'({we_p, dq_oe, oe_n}), 3'b011);
                    mem[{row_l[2:0], daddr[2:0]}] <= dq_o;
                end
            end
            if (!cas_n && !cas_p && (we_n != we_p)) we_moved <= 1'b1;
            if (cas_n && !cas_p)
                chk(!we_moved, "R8", "write enable steady under column strobe", int'(we_moved), 0);
            if (!cas_n && !oe_n && we_n && (caslo_c + 1 >= ACC))
                dq_i <= mem[{row_l[2:0], daddr[2:0]}];
            else
                dq_i <= ~mem[{row_l[2:0], daddr[2:0]}];
            ras_p <= ras_n; cas_p <= cas_n; we_p <= we_n;
        end
    end

    task automatic host_req(input logic [17:0] a, input logic w, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic host_read(input logic [17:0] a, output logic [3:0] d);
        int n = 0;
        host_req(a, 1'b0, 4'h0);
        while (!rd_valid && n < 200) begin @(negedge clk); n++; end
        d = rd_data;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes high in reset",
            int'({ras_n, cas_n, we_n, oe_n}), 15);
        chk(!dq_oe && !rd_valid && !ref_gnt, "R1", "drives low in reset",
            int'({dq_oe, rd_valid, ref_gnt}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ras_n && cas_n && !dq_oe, "R1", "quiet after reset", int'({ras_n, cas_n, dq_oe}), 6);
    endtask

    task automatic t_write_read();
        logic [3:0] d;
        int r0;
        host_req({9'h0A3, 9'h115}, 1'b1, 4'h9);
        r0 = rdv_cnt;
        host_read({9'h0A3, 9'h115}, d);
        chk(d == 4'h9, "R8", "read data after write", d, 9);
        chk(row_l == 9'h0A3, "R2", "row on row strobe", row_l, 9'h0A3);
        chk(col_l == 9'h115, "R2", "column on column strobe", col_l, 9'h115);
        repeat (4) @(negedge clk);
        chk(rdv_cnt - r0 == 1, "R8", "one read strobe per read", rdv_cnt - r0, 1);
    endtask

    task automatic t_page();
        logic [3:0] d1, d2;
        int a0, c0;
        a0 = acts; c0 = casf;
        host_req({9'h041, 9'h001}, 1'b1, 4'h5);
        host_req({9'h041, 9'h002}, 1'b1, 4'hC);
        host_read({9'h041, 9'h001}, d1);
        host_read({9'h041, 9'h002}, d2);
        chk(acts - a0 == 1, "R3", "activations for one row", acts - a0, 1);
        chk(casf - c0 == 4, "R3", "column strobes in page", casf - c0, 4);
        chk(d1 == 4'h5 && d2 == 4'hC, "R7", "page write data stored", {d1, d2}, 8'h5C);
    endtask

    task automatic t_row_miss();
        logic [3:0] d;
        int a0;
        a0 = acts;
        host_req({9'h002, 9'h003}, 1'b1, 4'h3);
        host_req({9'h003, 9'h003}, 1'b1, 4'hA);
        host_read({9'h002, 9'h003}, d);
        chk(acts - a0 == 3, "R4", "activations for alternating rows", acts - a0, 3);
        chk(d == 4'h3, "R4", "data survives row miss", d, 3);
    endtask

    task automatic t_budget();
        int run = 0, worst = 0;
        host_req({9'h005, 9'h004}, 1'b1, 4'h6);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            run = ras_n ? 0 : run + 1;
            if (run > worst) worst = run;
        end
        chk(ras_n == 1'b1, "R5", "idle row closed", int'(ras_n), 1);
        chk(worst <= RASMAX, "R5", "longest row low run", worst, RASMAX);
    endtask

    task automatic t_refresh();
        logic [3:0] d;
        int n = 0, c0, bad = 0;
        host_read({9'h006, 9'h007}, d);
        @(negedge clk);
        ref_req = 1'b1;
        while (!ref_gnt && n < 200) begin @(negedge clk); n++; end
        chk(ref_gnt == 1'b1, "R9", "grant given", int'(ref_gnt), 1);
        chk(ras_n && cas_n, "R9", "strobes high under grant", int'({ras_n, cas_n}), 3);
        c0 = casf;
        req_valid = 1'b1; req_addr = {9'h006, 9'h006}; req_we = 1'b1; req_wdata = 4'hE;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (req_ready || !ref_gnt || !ras_n) bad++;
        end
        chk(bad == 0, "R9", "host blocked during grant", bad, 0);
        chk(casf == c0, "R9", "no column strobe during grant", casf - c0, 0);
        ref_req = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        host_read({9'h006, 9'h006}, d);
        chk(d == 4'hE, "R10", "access after refresh", d, 14);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_page();
        t_row_miss();
        t_budget();
        t_refresh();
        repeat (40) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule